// File: doc/BRIEF.md
# SPI master with chip-select hold

This block is a register-programmed serial master that moves 8-bit words, most significant bit first, over a clock, a data-out line, a data-in line and one active-low chip select. Software writes a word into a one-entry transmit buffer. The shift engine takes the word from the buffer, drives the serial clock at a programmable rate, and places the received byte in a receive register that carries its own status flags. Software can write the next word while the current one is still shifting, so the clock keeps running from one word to the next.

Each word carries a keep bit. A word with keep set leaves chip select asserted when it ends. A word with keep clear releases chip select after a programmable trailing delay. A programmable leading delay separates the fall of chip select from the first clock pulse. The shift engine is a five-state machine. IDLE takes a buffered word and moves to LEAD, or moves straight to LOW when chip select is already held or the lead count is zero. LEAD moves to LOW when its count expires. LOW moves to HIGH at the end of the low half-bit. HIGH goes back to LOW for the next bit. After the last bit, HIGH goes to LOW for a buffered word under keep, to IDLE under keep with an empty buffer, to TRAIL without keep, or to IDLE without keep when the trail count is zero. TRAIL moves to IDLE when its count expires and releases chip select.

Top module: `spi_hold_master`

## Requirements
- R1: After the reset pin, or after a write to address 0 with bit 0 set, the block sleeps. While it sleeps, every other register reads zero, except address 4, which reads 1, and address 6, which reads 0x0100. Writes to other addresses are ignored. A write to address 0 with bit 0 clear and bit 1 set wakes the block. If both bits are set, bit 0 wins. Address 0 bit 0 reads 1 while the block is awake.
- R2: Words start only while the block is awake and address 1 holds master (bit 0) and enable (bit 1) both set. A transmit write made otherwise is ignored: tx_full stays 0 and the pins stay idle.
- R3: Each bit lasts N = max(P,1)+1 clock cycles, where P is address 2 bits [7:0]. SCLK is low for N − floor(N/2) cycles and then high for floor(N/2) cycles. SCLK is low whenever no bit is being shifted.
- R4: MOSI carries the word MSB first. Each bit is valid from the start of its low phase until SCLK falls at the end of the bit. MOSI is 0 in IDLE. MISO is captured on the clock edge where SCLK rises, and the received byte is assembled MSB first.
- R5: Address 3 bits [7:0] give the lead count. When a word starts with chip select released, chip select asserts and then stays asserted for that many cycles, with SCLK low and MOSI at the MSB, before the first low phase.
- R6: Address 3 bits [15:8] give the trail count. After the last high phase of a word with keep clear, chip select stays asserted for that many cycles, with SCLK low and MOSI at the LSB, and then returns to the idle level.
- R7: The transmit word at address 5 is laid out as data in [7:0], keep in bit 8 and target in bit 9. A word with keep set leaves chip select asserted after it ends. A following word then starts with no lead cycles: its first low phase comes right after the last high phase when it is already buffered, or on the second clock edge after its write otherwise.
- R8: Address 4 bit 0 sets the level chip select rests at when no word holds it. It resets to 1.
- R9: A word with target set, started while chip select is released, shifts normally, including its lead and trail cycles, but chip select stays at the idle level.
- R10: Address 6 bit 9 (tx_full) is 1 from a transmit write until the engine takes the word. A transmit write made while tx_full is 1 is ignored. A word written while another is shifting waits in the buffer and starts when the current word ends.
- R11: Reading address 6 returns the last received byte in [7:0] and rx_empty in bit 8. rx_empty clears when a word completes and sets on a read of address 6. An unread byte is overwritten by the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive flag at address 6 |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, driven low while asserted |

## Verification
A wrong state or counter in the engine shows up on the pins in the cycle where it first goes wrong. The cause might be a half-bit that is too long, a lead delay skipped under keep, or a chip select released early. The bench predicts SCLK, MOSI and chip select for every cycle of every word and compares them in that cycle. A wrong value in the buffer or receive flags shows up at the next read of address 6, which the bench makes after each sequence. The seamless handover between a held word and a buffered word is checked cycle by cycle across the word boundary.

// File: rtl/shm_pkg.sv
package shm_pkg;
    localparam int WORD_W = 8;
    localparam int CNT_W  = 8;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_GLB  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_FMT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_GAP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_IDLE = 3'd4;
    localparam logic [ADDR_W-1:0] A_TXW  = 3'd5;
    localparam logic [ADDR_W-1:0] A_RXW  = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL
    } shm_state_e;

    typedef struct packed {
        logic              tgt;
        logic              keep;
        logic [WORD_W-1:0] data;
    } shm_word_t;
endpackage

// File: rtl/shm_regs.sv
module shm_regs
    import shm_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              awake,
    output logic              go,
    output logic [CW-1:0]     pre,
    output logic [CW-1:0]     lead,
    output logic [CW-1:0]     trail,
    output logic              idle_lvl,
    output logic              buf_full,
    output shm_word_t         buf_word,
    input  logic              take,
    input  logic              rx_done,
    input  logic [WORD_W-1:0] rx_byte
);
    localparam int WW = $bits(shm_word_t);

    logic              awake_q, idle_q, tx_full_q, rx_empty_q;
    logic [1:0]        mode_q;
    logic [CW-1:0]     pre_q, lead_q, trail_q;
    shm_word_t         word_q;
    logic [WORD_W-1:0] rxb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            awake_q    <= 1'b0;
            mode_q     <= '0;
            pre_q      <= '0;
            lead_q     <= '0;
            trail_q    <= '0;
            idle_q     <= 1'b1;
            word_q     <= '0;
            tx_full_q  <= 1'b0;
            rx_empty_q <= 1'b1;
            rxb_q      <= '0;
        end else begin
            if (wr && addr == A_GLB) begin
                if (wdata[0])      awake_q <= 1'b0;
                else if (wdata[1]) awake_q <= 1'b1;
            end
            if (!awake_q) begin
                mode_q     <= '0;
                pre_q      <= '0;
                lead_q     <= '0;
                trail_q    <= '0;
                idle_q     <= 1'b1;
                word_q     <= '0;
                tx_full_q  <= 1'b0;
                rx_empty_q <= 1'b1;
                rxb_q      <= '0;
            end else begin
                if (wr) begin
                    case (addr)
                        A_MODE: mode_q <= wdata[1:0];
                        A_FMT:  pre_q  <= wdata[CW-1:0];
                        A_GAP: begin
                            lead_q  <= wdata[CW-1:0];
                            trail_q <= wdata[8 +: CW];
                        end
                        A_IDLE: idle_q <= wdata[0];
                        default: ;
                    endcase
                end
                if (take) tx_full_q <= 1'b0;
                if (wr && addr == A_TXW && go && !tx_full_q) begin
                    tx_full_q <= 1'b1;
                    word_q    <= shm_word_t'(wdata[WW-1:0]);
                end
                if (rd && addr == A_RXW) rx_empty_q <= 1'b1;
                if (rx_done) begin
                    rx_empty_q <= 1'b0;
                    rxb_q      <= rx_byte;
                end
            end
        end
    end

    always_comb begin
        awake    = awake_q;
        go       = awake_q && mode_q[0] && mode_q[1];
        pre      = pre_q;
        lead     = lead_q;
        trail    = trail_q;
        idle_lvl = idle_q;
        buf_full = tx_full_q;
        buf_word = word_q;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_GLB:  rdata[0] = awake_q;
            A_MODE: rdata[1:0] = mode_q;
            A_FMT:  rdata[CW-1:0] = pre_q;
            A_GAP: begin
                rdata[CW-1:0] = lead_q;
                rdata[8 +: CW] = trail_q;
            end
            A_IDLE: rdata[0] = idle_q;
            A_TXW:  rdata[WW-1:0] = word_q;
            A_RXW: begin
                rdata[WORD_W-1:0] = rxb_q;
                rdata[8] = rx_empty_q;
                rdata[9] = tx_full_q;
            end
            default: ;
        endcase
    end

    // R10
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !tx_full_q);

    // R2
    no_load_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !$rose(tx_full_q));

    // R11
    rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_empty_q);
endmodule

// File: rtl/shm_engine.sv
module shm_engine
    import shm_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              go,
    input  logic [CW-1:0]     pre,
    input  logic [CW-1:0]     lead,
    input  logic [CW-1:0]     trail,
    input  logic              buf_full,
    input  shm_word_t         buf_word,
    output logic              take,
    output logic              rx_done,
    output logic [WORD_W-1:0] rx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_on
);
    localparam int TW = CW + 1;
    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] TOP_BIT = BW'(WORD_W - 1);

    shm_state_e        state_q, state_d;
    logic [TW-1:0]     cnt_q, n_len, hi_len, lo_len, lead_len, trail_len;
    logic [BW-1:0]     bit_q;
    logic [WORD_W-1:0] tx_q, rx_q;
    logic              keep_q, cs_q;
    logic              lo_end, hi_end, last_bit;

    always_comb begin
        n_len     = (pre == '0) ? TW'(2) : TW'(pre) + TW'(1);
        hi_len    = n_len >> 1;
        lo_len    = n_len - hi_len;
        lead_len  = TW'(lead);
        trail_len = TW'(trail);
        lo_end    = (cnt_q == lo_len);
        hi_end    = (cnt_q == hi_len);
        last_bit  = (bit_q == '0);
    end

    always_comb begin : next_state
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE:
                if (go && buf_full) begin
                    take    = 1'b1;
                    state_d = (cs_q || lead == '0) ? ST_LOW : ST_LEAD;
                end
            ST_LEAD:
                if (cnt_q == lead_len) state_d = ST_LOW;
            ST_LOW:
                if (lo_end) state_d = ST_HIGH;
            ST_HIGH:
                if (hi_end) begin
                    if (!last_bit) begin
                        state_d = ST_LOW;
                    end else if (keep_q) begin
                        if (go && buf_full) begin
                            take    = 1'b1;
                            state_d = ST_LOW;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        state_d = (trail == '0) ? ST_IDLE : ST_TRAIL;
                    end
                end
            ST_TRAIL:
                if (cnt_q == trail_len) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin : state_reg
        if (!rst_n)   state_q <= ST_IDLE;
        else if (clr) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin : datapath
        if (!rst_n) begin
            cnt_q  <= TW'(1);
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            keep_q <= 1'b0;
            cs_q   <= 1'b0;
        end else if (clr) begin
            cnt_q  <= TW'(1);
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            keep_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            cnt_q <= (state_d != state_q) ? TW'(1) : cnt_q + TW'(1);
            if (take) begin
                tx_q   <= buf_word.data;
                keep_q <= buf_word.keep;
                bit_q  <= TOP_BIT;
                if (!cs_q) cs_q <= !buf_word.tgt;
            end else if (state_q == ST_HIGH && hi_end && !last_bit) begin
                tx_q  <= tx_q << 1;
                bit_q <= bit_q - BW'(1);
            end
            if (state_q == ST_LOW && lo_end) rx_q <= {rx_q[WORD_W-2:0], miso};
            if (state_d == ST_IDLE && state_q != ST_IDLE && !keep_q) cs_q <= 1'b0;
        end
    end

    always_comb begin : outputs
        sclk    = (state_q == ST_HIGH);
        mosi    = (state_q == ST_IDLE) ? 1'b0 : tx_q[WORD_W-1];
        cs_on   = cs_q;
        rx_done = (state_q == ST_HIGH) && hi_end && last_bit;
        rx_byte = rx_q;
    end

    // R6
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        ($fell(cs_q) && !$past(clr)) |-> ($past(state_q) == ST_TRAIL || $past(state_q) == ST_HIGH));

    // R3
    high_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state_q == ST_HIGH) |-> ($past(state_q) == ST_LOW || $past(state_q) == ST_HIGH));
endmodule

// File: rtl/spi_hold_master.sv
module spi_hold_master
    import shm_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic              awake, go, idle_lvl, buf_full, take, rx_done, cs_on;
    logic [CW-1:0]     pre, lead, trail;
    shm_word_t         buf_word;
    logic [WORD_W-1:0] rx_byte;

    shm_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .awake    (awake),
        .go       (go),
        .pre      (pre),
        .lead     (lead),
        .trail    (trail),
        .idle_lvl (idle_lvl),
        .buf_full (buf_full),
        .buf_word (buf_word),
        .take     (take),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte)
    );

    shm_engine #(.CW(CW)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!awake),
        .go       (go),
        .pre      (pre),
        .lead     (lead),
        .trail    (trail),
        .buf_full (buf_full),
        .buf_word (buf_word),
        .take     (take),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .cs_on    (cs_on)
    );

    assign spi_cs_n = cs_on ? 1'b0 : idle_lvl;
endmodule

// File: tb/spi_hold_master_bench.sv
module spi_hold_master_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk, rst_n, reg_wr, reg_rd, spi_miso;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    int checks = 0;
    int errors = 0;

    spi_hold_master u_spi_hold_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, got, exp, $time);
        end
    endtask

    // compare pins for this cycle, then advance one cycle
    task automatic step(input logic ecs, input logic esck, input logic emosi, input string tag);
        chk({15'd0, spi_cs_n}, {15'd0, ecs},   {tag, " cs_n"});
        chk({15'd0, spi_sclk}, {15'd0, esck},  {tag, " sclk"});
        chk({15'd0, spi_mosi}, {15'd0, emosi}, {tag, " mosi"});
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        chk(reg_rdata, exp, tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // reference waveform of one word: lead, then 8 bits of low/high phases
    task automatic run_word(input logic [7:0] d, input logic [7:0] r, input int lead,
                            input int n, input bit fresh, input logic ecs);
        int hi = n / 2;
        int lo = n - hi;
        if (fresh)
            for (int k = 0; k < lead; k++) step(ecs, 1'b0, d[7], "R5 lead");
        for (int b = 7; b >= 0; b--) begin
            for (int k = 0; k < lo; k++) begin
                spi_miso = r[b];
                step(ecs, 1'b0, d[b], "R3 R4 low");
            end
            for (int k = 0; k < hi; k++) step(ecs, 1'b1, d[b], "R3 R4 high");
        end
    endtask

    task automatic run_trail(input int t, input logic ecs, input logic lsb);
        for (int k = 0; k < t; k++) step(ecs, 1'b0, lsb, "R6 trail");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; spi_miso = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b0, "R8 reset idle");
        rd(3'd6, 16'h0100, "R1 reset rx status");

        // R1: asleep, writes ignored; wake
        wr(3'd1, 16'h0003);
        rd(3'd1, 16'h0000, "R1 mode ignored asleep");
        wr(3'd0, 16'h0002);
        rd(3'd0, 16'h0001, "R1 awake");

        // R2: master without enable ignores transmit writes
        wr(3'd1, 16'h0001);
        wr(3'd5, 16'h00A5);
        rd(3'd6, 16'h0100, "R2 tx_full stays 0");
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b0, "R2 pins idle");

        // word A: N=4, lead 2, trail 3
        wr(3'd1, 16'h0003);
        wr(3'd2, 16'h0003);
        wr(3'd3, 16'h0302);
        wr(3'd5, 16'h00C3);
        step(1'b1, 1'b0, 1'b0, "R5 before start");
        run_word(8'hC3, 8'h5A, 2, 4, 1'b1, 1'b0);
        run_trail(3, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, "R6 released");
        rd(3'd6, 16'h005A, "R11 rx byte");
        rd(3'd6, 16'h015A, "R11 rx_empty after read");

        // back-to-back: held word then buffered word, N=5, lead 1, trail 0
        wr(3'd2, 16'h0004);
        wr(3'd3, 16'h0001);
        fork
            begin
                wr(3'd5, 16'h0196);
                step(1'b1, 1'b0, 1'b0, "R7 before start");
                run_word(8'h96, 8'h3C, 1, 5, 1'b1, 1'b0);
                run_word(8'h4B, 8'hE1, 1, 5, 1'b0, 1'b0);
                step(1'b1, 1'b0, 1'b0, "R7 released after unkept word");
            end
            begin
                repeat (4) @(negedge clk);
                wr(3'd5, 16'h004B);
                wr(3'd5, 16'h00FF);
                rd(3'd6, 16'h035A, "R10 tx_full while buffered");
            end
        join
        rd(3'd6, 16'h00E1, "R11 overwrite unread byte");

        // held idle gap: N=2 (P=0), lead 4, trail 2
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0204);
        wr(3'd5, 16'h0181);
        step(1'b1, 1'b0, 1'b0, "R7 before start");
        run_word(8'h81, 8'h00, 4, 2, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, "R7 held in idle");
        wr(3'd5, 16'h007E);
        step(1'b0, 1'b0, 1'b0, "R7 held before next");
        run_word(8'h7E, 8'hFF, 4, 2, 1'b0, 1'b0);
        run_trail(2, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, "R6 released");
        rd(3'd6, 16'h00FF, "R11 rx byte");

        // R9: target set keeps chip select at idle level
        wr(3'd5, 16'h023C);
        step(1'b1, 1'b0, 1'b0, "R9 before start");
        run_word(8'h3C, 8'h00, 4, 2, 1'b1, 1'b1);
        run_trail(2, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, "R9 after");

        // R8: idle level programmable
        wr(3'd4, 16'h0000);
        step(1'b0, 1'b0, 1'b0, "R8 idle low");
        step(1'b0, 1'b0, 1'b0, "R8 idle low");
        wr(3'd4, 16'h0001);
        step(1'b1, 1'b0, 1'b0, "R8 idle high");

        // R1: soft reset mid-word
        wr(3'd5, 16'h00AA);
        repeat (5) @(negedge clk);
        wr(3'd0, 16'h0001);
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, "R1 pins after soft reset");
        rd(3'd6, 16'h0100, "R1 rx status after soft reset");
        rd(3'd1, 16'h0000, "R1 mode cleared");
        rd(3'd2, 16'h0000, "R1 prescale cleared");
        wr(3'd5, 16'h0055);
        rd(3'd6, 16'h0100, "R1 tx write ignored asleep");
        wr(3'd0, 16'h0003);
        rd(3'd0, 16'h0000, "R1 reset bit wins");

        summary();
        $finish;
    end
endmodule